// File: doc/BRIEF.md
# Smart Card Clock Divider with Park Control

This block derives the clock that drives a contact smart card from a 27.12 MHz reference. A 3-bit code picks one of seven integer division ratios (2, 3, 4, 5, 6, 8, 16), so the fastest card clock is 13.56 MHz. The output comes straight from a register. A new ratio is adopted only where a full output period ends, so a change never produces a shortened high or low phase.

The card clock can be frozen at either logic level. A stop request waits for the next output edge that moves the clock to the chosen park level, and the output is then held there. A status output reports the frozen state one reference cycle after the output has settled. On release the clock resumes from the park level with a phase of full length.

Top module: `card_clk_div`

## Requirements
- R1: While `rst_n` is low at a rising reference edge, `card_clk` and `stopped` are 0 after that edge. At the first reference edge with `rst_n` high, `card_clk` rises and the ratio selected by `div_sel` becomes active.
- R2: `div_sel` codes 0, 1, 2, 3, 4, 5, 6 give card clock periods of 2, 3, 4, 5, 6, 8 and 16 reference cycles respectively.
- R3: Each period is high for ceil(N/2) reference cycles and low for floor(N/2), so odd ratios have the longer phase high.
- R4: Code 7 is ignored: the ratio in use stays unchanged.
- R5: `div_sel` is sampled only on the reference edge where `card_clk` rises. A change at any other time does not affect the period in progress.
- R6: When `stop_req` is high at an edge that moves `card_clk` to the level given by `stop_lvl` (1 = high, 0 = low), the output stays at that level for as long as `stop_req` remains high.
- R7: `stopped` rises one reference cycle after the edge that parked the output. It falls one cycle after the first edge that samples `stop_req` low while parked.
- R8: After the edge that samples `stop_req` low while parked, `card_clk` stays at the park level for exactly ceil(N/2) cycles (parked high) or floor(N/2) cycles (parked low) before its next edge. N is the ratio in use when the clock parked.
- R9: Changes of `stop_lvl` while the clock is parked have no effect on `card_clk` or `stopped`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27.12 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 3 | Division ratio code |
| stop_req | input | 1 | Request to park the card clock |
| stop_lvl | input | 1 | Park level: 1 holds high, 0 holds low |
| card_clk | output | 1 | Card clock output |
| stopped | output | 1 | Card clock is parked |

## Verification
Every valid code is measured over a settled period, which separates the seven ratios and checks the odd-ratio duty split. Codes are then changed at a sweep of offsets within a period. Code 7 is tried after both even and odd ratios, which would expose a ratio taken up mid-period or an unused code mapped to a live ratio. Stops at both park levels are requested from the opposite level, the park level is changed while parked, and the clock is released. These runs separate an early or late park, a stray status edge and a short first phase after restart. A long random mix of codes and stop requests is then compared cycle by cycle with the reference model.

// File: rtl/ccd_pkg.sv
// Shared constants and the ratio code table for the card clock divider.
// Assumes the reference clock is the only clock; all values are static.
package ccd_pkg;
    localparam int CCD_CODE_W      = 3;
    localparam int CCD_RATIO_W     = 5;
    localparam int CCD_RESET_RATIO = 16;

    // Returns the division ratio for a code, or 0 for a reserved code.
    function automatic int code_ratio(input int code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 8;
            6:       return 16;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/ccd_ratio_map.sv
// Decodes the ratio select code into a division ratio and a valid flag.
// Assumes reserved codes map to ratio 0 in the package table; purely combinational.
module ccd_ratio_map #(
    parameter int CODE_W  = ccd_pkg::CCD_CODE_W,
    parameter int RATIO_W = ccd_pkg::CCD_RATIO_W
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio,
    output logic               valid
);
    localparam int NCODES = 1 << CODE_W;

    logic [RATIO_W-1:0] ratio_tbl [NCODES];
    logic [NCODES-1:0]  valid_tbl;

    // One table entry per code, computed from the package function.
    for (genvar g = 0; g < NCODES; g++) begin : g_entry
        localparam int R = ccd_pkg::code_ratio(g);
        assign ratio_tbl[g] = RATIO_W'(R);
        assign valid_tbl[g] = (R >= 2);
    end

    // Select the entry for the current code.
    always_comb begin
        ratio = ratio_tbl[code];
        valid = valid_tbl[code];
    end
endmodule

// File: rtl/ccd_phase_ctr.sv
// Position counter within one card clock period; flags the reference cycles
// whose closing edge raises or lowers the output. Latches a new ratio only on
// the period wrap. Assumes hold is high while the output is parked.
module ccd_phase_ctr #(
    parameter int RATIO_W     = ccd_pkg::CCD_RATIO_W,
    parameter int RESET_RATIO = ccd_pkg::CCD_RESET_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_vld,
    output logic [RATIO_W-1:0] cnt,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               rise_evt,
    output logic               fall_evt
);
    localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] RST_RAT = RATIO_W'(RESET_RATIO);

    logic [RATIO_W-1:0] hi_len;
    logic [RATIO_W-1:0] last_pos;
    logic [RATIO_W-1:0] hi_last;

    // Phase boundaries of the ratio in use; the high phase takes the odd cycle.
    always_comb begin
        hi_len   = (ratio_q + ONE) >> 1;
        last_pos = ratio_q - ONE;
        hi_last  = hi_len - ONE;
    end

    // Edge events for the output register, suppressed while parked.
    always_comb begin
        rise_evt = !hold && (cnt == last_pos);
        fall_evt = !hold && (cnt == hi_last) && (cnt != last_pos);
    end

    // Count positions, wrapping at the period end where a new ratio is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RST_RAT - ONE;
            ratio_q <= RST_RAT;
        end else if (rise_evt) begin
            cnt <= '0;
            if (ratio_vld) ratio_q <= ratio_in;
        end else if (!hold) begin
            cnt <= cnt + ONE;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio_q);

    // R5
    ratio_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_q) |-> ($past(cnt) == $past(ratio_q) - ONE));
endmodule

// File: rtl/ccd_park_ctl.sv
// Output register and park control: drives the card clock on the counter's
// events, freezes it at the requested level and reports the frozen state one
// cycle later. Assumes no events arrive while parked.
module ccd_park_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic stop_req,
    input  logic stop_lvl,
    output logic clk_q,
    output logic parked_q,
    output logic stopped
);
    logic park_now;

    // Park when the coming edge lands the output on the requested level.
    always_comb begin
        park_now = stop_req && ((rise_evt && stop_lvl) || (fall_evt && !stop_lvl));
    end

    // Output register follows the counter events.
    always_ff @(posedge clk) begin
        if (!rst_n)        clk_q <= 1'b0;
        else if (rise_evt) clk_q <= 1'b1;
        else if (fall_evt) clk_q <= 1'b0;
    end

    // Park flag: set on a matching edge, cleared when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                     parked_q <= 1'b0;
        else if (parked_q && !stop_req) parked_q <= 1'b0;
        else if (!parked_q && park_now) parked_q <= 1'b1;
    end

    // Status lags the park flag by one cycle so the output has settled.
    always_ff @(posedge clk) begin
        if (!rst_n) stopped <= 1'b0;
        else        stopped <= parked_q;
    end

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parked_q && stop_req |=> $stable(clk_q));

    // R7
    stopped_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> $stable(clk_q));
endmodule

// File: rtl/card_clk_div.sv
// Smart card clock divider top: ratio decode, period counter and park
// control. Assumes clk is the 27.12 MHz reference; all inputs synchronous.
module card_clk_div #(
    parameter int CODE_W  = ccd_pkg::CCD_CODE_W,
    parameter int RATIO_W = ccd_pkg::CCD_RATIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_sel,
    input  logic              stop_req,
    input  logic              stop_lvl,
    output logic              card_clk,
    output logic              stopped
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] sel_ratio;
    logic               sel_valid;
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] ratio_q;
    logic               rise_evt;
    logic               fall_evt;
    logic               parked_q;

    ccd_ratio_map #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) i_map (
        .code  (div_sel),
        .ratio (sel_ratio),
        .valid (sel_valid)
    );

    ccd_phase_ctr #(.RATIO_W(RATIO_W)) i_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (parked_q),
        .ratio_in  (sel_ratio),
        .ratio_vld (sel_valid),
        .cnt       (cnt),
        .ratio_q   (ratio_q),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt)
    );

    ccd_park_ctl i_park (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .stop_req (stop_req),
        .stop_lvl (stop_lvl),
        .clk_q    (card_clk),
        .parked_q (parked_q),
        .stopped  (stopped)
    );

    // R3
    edge_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(card_clk) |->
            (($past(cnt) == $past(ratio_q) - ONE) ||
             ($past(cnt) == (($past(ratio_q) + ONE) >> 1) - ONE)));
endmodule

// File: tb/test_card_clk_div.sv
module test_card_clk_div;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       stop_req = 1'b0;
    logic       stop_lvl = 1'b0;
    logic       card_clk;
    logic       stopped;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    cmp_en = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_out = 0, m_left = 1, m_ratio = 16, m_parked = 0, m_stopped = 0;
    int ratio_list [7] = '{2, 3, 4, 5, 6, 8, 16};

    card_clk_div i_card_clk_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .stop_req(stop_req),
        .stop_lvl(stop_lvl), .card_clk(card_clk), .stopped(stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural model: remaining cycles in the current phase
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_left = 1; m_ratio = 16; m_parked = 0; m_stopped = 0;
        end else begin
            m_stopped = m_parked;
            if (m_parked != 0) begin
                if (!stop_req) begin
                    m_parked = 0;
                    m_left = (m_out != 0) ? (m_ratio + 1) / 2 : m_ratio / 2;
                end
            end else if (m_left > 1) begin
                m_left--;
            end else if (m_out == 0) begin
                if (div_sel != 3'd7) m_ratio = ratio_list[div_sel];
                m_out = 1;
                m_left = (m_ratio + 1) / 2;
                if (stop_req && stop_lvl) m_parked = 1;
            end else begin
                m_out = 0;
                m_left = m_ratio / 2;
                if (stop_req && !stop_lvl) m_parked = 1;
            end
            cmp_en = 1'b1;
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(card_clk == m_out[0], cur_req, "card_clk vs model", card_clk, m_out);
            chk(stopped == m_stopped[0], cur_req, "stopped vs model", stopped, m_stopped);
        end
    end

    // measure one settled period and its high time
    task automatic measure(input int code, input int exp_n);
        int per = 0, hi = 0;
        bit prev = card_clk;
        forever begin
            @(negedge clk);
            if (card_clk && !prev) break;
            prev = card_clk;
        end
        prev = 1'b1;
        forever begin
            per++;
            if (card_clk) hi++;
            @(negedge clk);
            if (card_clk && !prev) break;
            prev = card_clk;
        end
        chk(per == exp_n, "R2", $sformatf("period code %0d", code), per, exp_n);
        chk(hi == (exp_n + 1) / 2, "R3", $sformatf("high time code %0d", code), hi, (exp_n + 1) / 2);
    endtask

    // park at lvl from the opposite level and check status timing
    task automatic park_test(input bit lvl);
        while (card_clk == lvl) @(negedge clk);
        stop_lvl = lvl;
        stop_req = 1'b1;
        cur_req = "R6";
        while (card_clk != lvl) @(negedge clk);
        chk(stopped == 1'b0, "R7", "stopped on park edge", stopped, 0);
        @(negedge clk);
        chk(stopped == 1'b1, "R7", "stopped one cycle later", stopped, 1);
        repeat (20) @(negedge clk);
        chk(card_clk == lvl, "R6", "held at park level", card_clk, lvl);
        cur_req = "R9";
        stop_lvl = !lvl;
        repeat (10) @(negedge clk);
        chk(card_clk == lvl, "R9", "level change ignored", card_clk, lvl);
        chk(stopped == 1'b1, "R9", "status kept", stopped, 1);
        stop_lvl = lvl;
        cur_req = "R8";
        stop_req = 1'b0;
        @(negedge clk);
        begin
            int stay = 0;
            while (card_clk == lvl && stay < 40) begin
                stay++;
                @(negedge clk);
            end
            chk(stay == (lvl ? 3 : 2), "R8", "first phase after release", stay, lvl ? 3 : 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(card_clk == 1'b0, "R1", "card_clk in reset", card_clk, 0);
        chk(stopped == 1'b0, "R1", "stopped in reset", stopped, 0);
        div_sel = 3'd2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(card_clk == 1'b1, "R1", "first rise after reset", card_clk, 1);

        for (int c = 0; c < 7; c++) begin
            cur_req = "R2";
            div_sel = 3'(c);
            repeat (40) @(negedge clk);
            measure(c, ratio_list[c]);
        end

        cur_req = "R4";
        div_sel = 3'd6;
        repeat (40) @(negedge clk);
        div_sel = 3'd7;
        repeat (40) @(negedge clk);
        measure(7, 16);
        div_sel = 3'd3;
        repeat (40) @(negedge clk);
        div_sel = 3'd7;
        repeat (20) @(negedge clk);
        measure(7, 5);

        cur_req = "R5";
        for (int k = 1; k <= 14; k++) begin
            repeat (k) @(negedge clk);
            div_sel = 3'(k % 8);
        end

        div_sel = 3'd3;
        repeat (40) @(negedge clk);
        park_test(1'b0);
        repeat (20) @(negedge clk);
        park_test(1'b1);

        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 9) == 0) div_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 19) == 0) stop_req = !stop_req;
            if ($urandom_range(0, 29) == 0) stop_lvl = !stop_lvl;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule